// File: doc/BRIEF.md
# BPSK Carrier Modulator

This block turns a serial stream of symbols into binary phase-shift keyed samples for a digital-to-analog converter. A free-running phase index walks a cosine table to produce the local carrier. A saturating negation forms the opposite-phase copy. A sign test on the input decides the symbol. The test is taken once per bit period, on the last clock of that period. A two-way multiplexer then emits either the carrier or its negation as a signed 16-bit sample.

The carrier phase never resets at a symbol change, so a phase reversal comes only from the multiplexer. The symbol select is delayed to match the table read latency, so carrier sample and decision always belong to the same clock. A valid strobe marks the samples that have passed through the full pipeline since reset.

Top module: `bpsk_mod`

## Requirements
- R1: While the synchronous reset `rst` is high, `dout` reads 0 and `dout_valid` reads 0 after each rising edge.
- R2: After reset is released, `dout_valid` is low after the first TBL_LAT rising edges (edge indices 0 to TBL_LAT-1; default TBL_LAT = 1). It is high from edge index TBL_LAT on, and stays high until reset.
- R3: The inverted carrier saturates. A carrier value of -32768 gives an output of +32767, never -32768.
- R4: Carrier entry k (of N = 64) equals 32768*cos(2*pi*k/64), rounded half away from zero and clamped to the range -32768 to +32767. The phase index is 0 after reset and advances by one per clock without regard to symbol boundaries.
- R5: The decision is 1 when the two's complement input `din` is greater than or equal to zero, zero included. It is 0 when `din` is negative.
- R6: The decision is captured only on the last clock of each bit period, at edge indices P-1, 2P-1 and so on, where P is `bit_period`. Input values on the other clocks have no effect on the output.
- R7: The sample after edge index e is entry ((e - TBL_LAT) mod 64) itself when the decision held after edge e - TBL_LAT is 1. It is the saturated negation of that entry when the decision is 0.
- R8: A `bit_period` of 0 or 1 captures a decision on every clock.
- R9: Reset sets the decision to 1, so every sample before the first capture carries the non-inverted carrier whatever `din` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 16 | Signed symbol input; its sign chooses the phase |
| bit_period | input | 16 | Clocks per symbol; 0 and 1 both mean one clock |
| dout | output | 16 | Signed modulated sample for the converter |
| dout_valid | output | 1 | High when `dout` carries a sample through the full pipeline |

## Verification
The hardest case to reach is the saturating negation. It needs the table entry at half a carrier period, which is -32768, to meet a 0 decision. The bench holds the input at its most negative value with a short bit period and runs past sample 32 of the carrier, so that entry arrives while the negated path is selected. Mid-symbol input changes are driven on every clock with a mixed-sign pattern against a 5-clock period. A model that samples only on period ends then exposes any capture at the wrong clock.

// File: rtl/bpsk_pkg.sv
`timescale 1ns/1ps
package bpsk_pkg;

   // Cosine entry k of n, scaled to a w-bit signed full scale,
   // rounded half away from zero and clamped to the signed range.
   function automatic int cos_entry(int k, int n, int w);
      real amp;
      real r;
      int  v;
      int  hi;
      int  lo;
      amp = 2.0 ** (w - 1);
      r   = amp * $cos(2.0 * 3.14159265358979323846 * real'(k) / real'(n));
      if (r >= 0.0) v = $rtoi(r + 0.5);
      else          v = -$rtoi(0.5 - r);
      hi = (1 << (w - 1)) - 1;
      lo = -(1 << (w - 1));
      if (v > hi) v = hi;
      if (v < lo) v = lo;
      return v;
   endfunction

endpackage

// File: rtl/bpsk_carrier_rom.sv
`timescale 1ns/1ps
module bpsk_carrier_rom #(
   parameter int OUT_W   = 16,
   parameter int LUT_AW  = 6,
   parameter int STEP    = 1,
   parameter int TBL_LAT = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   output logic signed [OUT_W-1:0] car
);
   localparam int N = 2 ** LUT_AW;
   localparam logic [LUT_AW-1:0] STEP_V = LUT_AW'(STEP);

   logic signed [OUT_W-1:0] tbl [N];
   logic signed [OUT_W-1:0] pipe [TBL_LAT];
   logic [LUT_AW-1:0]       phase_q;

   // table computed at elaboration
   for (genvar k = 0; k < N; k++) begin : g_tbl
      localparam logic signed [31:0] CV = 32'(bpsk_pkg::cos_entry(k, N, OUT_W));
      assign tbl[k] = CV[OUT_W-1:0];
   end

   // phase runs freely; symbol changes never touch it
   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + STEP_V;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < TBL_LAT; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= tbl[phase_q];
         for (int i = 1; i < TBL_LAT; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign car = pipe[TBL_LAT-1];
endmodule

// File: rtl/bpsk_sym_decide.sv
`timescale 1ns/1ps
module bpsk_sym_decide #(
   parameter int IN_W  = 16,
   parameter int PER_W = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] din,
   input  logic [PER_W-1:0]       bit_period,
   output logic                   tick,
   output logic                   dec
);
   logic [PER_W-1:0] cnt_q;
   logic             dec_q;

   // last clock of the period; 0 and 1 both mean every clock
   assign tick = (bit_period <= PER_W'(1)) ? 1'b1 : (cnt_q >= bit_period - 1'b1);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   // threshold at zero: non-negative selects the plain carrier
   always_ff @(posedge clk) begin
      if (rst)       dec_q <= 1'b1;
      else if (tick) dec_q <= ~din[IN_W-1];
   end

   assign dec = dec_q;
endmodule

// File: rtl/bpsk_phase_mux.sv
`timescale 1ns/1ps
module bpsk_phase_mux #(
   parameter int OUT_W   = 16,
   parameter int TBL_LAT = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [OUT_W-1:0] car,
   input  logic                    dec,
   output logic                    sel,
   output logic signed [OUT_W-1:0] dout,
   output logic                    dout_valid
);
   localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic signed [OUT_W-1:0] MAXV = ~MINV;

   logic signed [OUT_W-1:0] ncar;
   logic signed [OUT_W-1:0] dout_q;
   logic [TBL_LAT:0]        vld_q;

   // align the decision with the table read latency
   if (TBL_LAT == 1) begin : g_sel_direct
      assign sel = dec;
   end else begin : g_sel_delay
      logic [TBL_LAT-2:0] sel_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            sel_q <= '1;
         end else begin
            sel_q[0] <= dec;
            for (int i = 1; i < TBL_LAT - 1; i++) sel_q[i] <= sel_q[i-1];
         end
      end
      assign sel = sel_q[TBL_LAT-2];
   end

   assign ncar = (car == MINV) ? MAXV : -car;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q <= '0;
         vld_q  <= '0;
      end else begin
         dout_q <= sel ? car : ncar;
         vld_q  <= {vld_q[TBL_LAT-1:0], 1'b1};
      end
   end

   assign dout       = dout_q;
   assign dout_valid = vld_q[TBL_LAT];
endmodule

// File: rtl/bpsk_mod.sv
`timescale 1ns/1ps
module bpsk_mod #(
   parameter int IN_W    = 16,
   parameter int OUT_W   = 16,
   parameter int PER_W   = 16,
   parameter int LUT_AW  = 6,
   parameter int STEP    = 1,
   parameter int TBL_LAT = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [IN_W-1:0]  din,
   input  logic [PER_W-1:0]        bit_period,
   output logic signed [OUT_W-1:0] dout,
   output logic                    dout_valid
);
   if (IN_W < 2)                     begin : g_bad_in  $error("IN_W must be at least 2"); end
   if (OUT_W < 4 || OUT_W > 24)      begin : g_bad_out $error("OUT_W must be 4..24"); end
   if (PER_W < 1)                    begin : g_bad_per $error("PER_W must be positive"); end
   if (LUT_AW < 2 || LUT_AW > 10)    begin : g_bad_aw  $error("LUT_AW must be 2..10"); end
   if (TBL_LAT < 1 || TBL_LAT > 4)   begin : g_bad_lat $error("TBL_LAT must be 1..4"); end

   logic signed [OUT_W-1:0] car;
   logic                    sym_tick;
   logic                    sym_dec;
   logic                    mux_sel;

   bpsk_carrier_rom #(
      .OUT_W(OUT_W), .LUT_AW(LUT_AW), .STEP(STEP), .TBL_LAT(TBL_LAT)
   ) rom_i (
      .clk(clk), .rst(rst), .car(car)
   );

   bpsk_sym_decide #(
      .IN_W(IN_W), .PER_W(PER_W)
   ) dec_i (
      .clk(clk), .rst(rst), .din(din), .bit_period(bit_period),
      .tick(sym_tick), .dec(sym_dec)
   );

   bpsk_phase_mux #(
      .OUT_W(OUT_W), .TBL_LAT(TBL_LAT)
   ) mux_i (
      .clk(clk), .rst(rst), .car(car), .dec(sym_dec), .sel(mux_sel),
      .dout(dout), .dout_valid(dout_valid)
   );
endmodule

// File: rtl/bpsk_mod_chk.sv
`timescale 1ns/1ps
module bpsk_mod_chk #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst,
   input logic signed [IN_W-1:0]  din,
   input logic signed [OUT_W-1:0] dout,
   input logic                    dout_valid,
   input logic                    tick,
   input logic                    dec,
   input logic                    sel
);
   localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

   p_valid_hold_r2: assert property (@(posedge clk) disable iff (rst)
      dout_valid |=> dout_valid);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      !sel |=> (dout != MINV));

   p_thresh_r5: assert property (@(posedge clk) disable iff (rst)
      tick |=> (dec == !$past(din[IN_W-1])));

   p_dec_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(dec));

   p_rst_sel_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> dec);
endmodule

bind bpsk_mod bpsk_mod_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
   .clk(clk), .rst(rst), .din(din), .dout(dout), .dout_valid(dout_valid),
   .tick(sym_tick), .dec(sym_dec), .sel(mux_sel)
);

// File: tb/bpsk_mod_tb_top.sv
`timescale 1ns/1ps
module bpsk_mod_tb_top;
   localparam int LAT  = 1;
   localparam int NTAB = 64;
   localparam int MINV = -32768;
   localparam int MAXV = 32767;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic signed [15:0] din = '0;
   logic [15:0]        bit_period = 16'd4;
   logic signed [15:0] dout;
   logic               dout_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   bpsk_mod dut_i (
      .clk(clk), .rst(rst), .din(din), .bit_period(bit_period),
      .dout(dout), .dout_valid(dout_valid)
   );

   function automatic int cos_ref(int k);
      real r;
      int  v;
      r = 32768.0 * $cos(2.0 * 3.14159265358979323846 * real'(k) / real'(NTAB));
      if (r >= 0.0) v = $rtoi(r + 0.5);
      else          v = -$rtoi(0.5 - r);
      if (v > MAXV) v = MAXV;
      if (v < MINV) v = MINV;
      return v;
   endfunction

   function automatic logic signed [15:0] pat(int mode, int e);
      case (mode)
         0: return 16'sd1200;
         1: return -16'sd32768;
         2: return 16'sd0;
         3: return -16'sd1;
         4: return (((e * 7 + e / 11) % 5) < 2) ? -16'sd5 : 16'sd9;
         5: return (((e / 6) % 2) == 1) ? -16'sd300 : 16'sd300;
         default: return 16'sd0;
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // reset with period p, then stream n clocks of pattern mode against the model
   task automatic run_stream(int p, int mode, int n, string base);
      int peff;
      bit dec_m;
      bit ring [4];
      peff  = (p == 0) ? 1 : p;
      dec_m = 1'b1;
      @(negedge clk);
      rst = 1'b1;
      bit_period = 16'(p);
      din = pat(mode, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dout == 16'sd0, "R1 dout", int'(dout), 0);
      chk(dout_valid == 1'b0, "R1 valid", int'(dout_valid), 0);
      rst = 1'b0;
      for (int e = 0; e < n; e++) begin
         @(posedge clk);
         if ((e % peff) == peff - 1) dec_m = (pat(mode, e) >= 0);
         ring[e % 4] = dec_m;
         @(negedge clk);
         if (e < LAT) begin
            chk(dout_valid == 1'b0, "R2 early", int'(dout_valid), 0);
         end else begin
            int    c;
            int    expv;
            bit    d;
            string tag;
            chk(dout_valid == 1'b1, "R2 steady", int'(dout_valid), 1);
            c    = cos_ref((e - LAT) % NTAB);
            d    = ring[(e - LAT) % 4];
            expv = d ? c : ((c == MINV) ? MAXV : -c);
            tag  = base;
            if (!d && c == MINV)      tag = "R3";
            else if (e - LAT < peff - 1) tag = "R9";
            chk(int'(dout) == expv, tag, int'(dout), expv);
         end
         din = pat(mode, e + 1);
      end
   endtask

   task automatic t_carrier_r4();      run_stream(7, 0, 140, "R4");  endtask
   task automatic t_inverted_r3();     run_stream(3, 1, 140, "R7");  endtask
   task automatic t_zero_input_r5();   run_stream(4, 2, 80,  "R5");  endtask
   task automatic t_minus_one_r5();    run_stream(4, 3, 80,  "R5");  endtask
   task automatic t_midsymbol_r6();    run_stream(5, 4, 200, "R6");  endtask
   task automatic t_period_zero_r8();  run_stream(0, 4, 100, "R8");  endtask
   task automatic t_period_one_r8();   run_stream(1, 5, 100, "R8");  endtask
   task automatic t_alternate_r7();    run_stream(6, 5, 160, "R7");  endtask
   task automatic t_reset_sel_r9();    run_stream(40, 1, 120, "R9"); endtask

   initial begin
      t_carrier_r4();
      t_inverted_r3();
      t_zero_input_r5();
      t_minus_one_r5();
      t_midsymbol_r6();
      t_period_zero_r8();
      t_period_one_r8();
      t_alternate_r7();
      t_reset_sel_r9();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule